// File: doc/BRIEF.md
# Parallel IO Port Controller with Peripheral Handover

This block controls a bank of general-purpose IO pins (32 by default) from a plain synchronous register port. Each pin is owned either by the controller, which then drives the pin from its own data and direction settings, or by one of two peripheral functions, named A and B, which then drive the pad directly. Every per-pin attribute is a single state bit. Software changes it through a pair of write-one-to-act addresses: one sets the bit and the other clears it. A third address reads the bit back. The attributes are ownership, direction, output data, input filtering, open-drain drive, pull-up and interrupt mask.

Each pin input passes through a two-stage synchroniser, then through an optional two-sample glitch filter, and sets a change flag on every accepted transition in either direction. Reading the change-flag register returns the flags and clears them. A single interrupt line stays high while any unmasked flag is set. An open-drain pin drives the pad only to 0 and releases it for a 1.

Top module: `pio_port_ctrl`

## Requirements
- R1: After reset every pin is controller-owned with A selected, direction is input (pad_oe all 0), output data is 0, pull-ups are on (pad_pullup all 1), filters, open-drain and interrupt masks are off, the change flags are empty and irq is 0.
- R2: For each attribute pair, a write to the set address sets every bit that is 1 in the data. A write to the clear address clears every bit that is 1 in the data. A 0 bit leaves its pin unchanged, and the status address returns the current bits.
- R3: A controller-owned pin drives pad_out from its data bit and pad_oe from its direction bit. A pin whose ownership bit is cleared takes alt_b_out/alt_b_oe when its select bit is 1, and alt_a_out/alt_a_oe otherwise. Writing 1 to 0x74 sets select bits (B). Writing 1 to 0x70 clears them (A). 0x78 reads them back.
- R4: On an open-drain pin, pad_out is 0. pad_oe is deasserted when the selected output value is 1 and follows the selected enable when the value is 0.
- R5: pad_pullup carries the pull-up state. The pull-up status address returns the inverse, so a 1 means the pull-up is off.
- R6: The level address 0x88 returns the filtered synchronised level of every pin, whatever its owner. With the filter off, a pin change applied before clock edge 1 appears after edge 3.
- R7: With the filter on, a level that lasts one clock sample is ignored. A new level is accepted only after two consecutive synchronised samples agree, so it appears one edge later than without the filter.
- R8: Each accepted rising or falling transition sets the pin's change flag. A read of 0x98 returns the flags and clears them, but a transition that is accepted in the same cycle as that read stays pending.
- R9: irq is 1 exactly while a change flag and the same pin's mask bit are both 1.
- R10: Address bits [7:4] pick the group (0 ownership, 1 direction, 2 data, 3 filter, 4 open-drain, 5 pull-up, 6 mask, 7 select, 8 level, 9 change flags). Bits [3:2] pick the slot (0 set, 1 clear, 2 status). Read data appears the cycle after bus_rd. Reads of set or clear slots and of unused addresses return 0, and writes to status slots have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data, one bit per pin |
| bus_rdata | output | 32 | Read data, registered |
| pin_in | input | N_PINS | Pad input levels (asynchronous) |
| alt_a_out | input | N_PINS | Peripheral A output values |
| alt_a_oe | input | N_PINS | Peripheral A output enables |
| alt_b_out | input | N_PINS | Peripheral B output values |
| alt_b_oe | input | N_PINS | Peripheral B output enables |
| pad_out | output | N_PINS | Pad output value |
| pad_oe | output | N_PINS | Pad output enable |
| pad_pullup | output | N_PINS | Pad pull-up enable |
| irq | output | 1 | Unmasked pin-change interrupt |

## Verification
A pin transition accepted by the input stage can land in the same cycle as a software read of the change flags. Because the read clears the flags, a flag set in that cycle would be lost unless the set takes priority over the clear. The bench changes a pin and issues the read so that its clock edge is the third edge after the change, which is the edge where the unfiltered transition is accepted. It then expects the read to return the old flags without that pin, a second read to return that pin's flag, and a third read to return nothing.

// File: rtl/pio_pkg.sv
// pio_pkg: shared address decode constants for the IO port controller.
// Assumes byte addresses with group in [7:4] and slot in [3:2].
package pio_pkg;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int NUM_CFG = 8;

    localparam logic [3:0] G_OWN = 4'd0;
    localparam logic [3:0] G_OE  = 4'd1;
    localparam logic [3:0] G_DAT = 4'd2;
    localparam logic [3:0] G_FLT = 4'd3;
    localparam logic [3:0] G_MD  = 4'd4;
    localparam logic [3:0] G_PU  = 4'd5;
    localparam logic [3:0] G_IM  = 4'd6;
    localparam logic [3:0] G_SEL = 4'd7;
    localparam logic [3:0] G_LVL = 4'd8;
    localparam logic [3:0] G_CHG = 4'd9;

    typedef enum logic [1:0] {
        SLOT_SET = 2'd0,
        SLOT_CLR = 2'd1,
        SLOT_STS = 2'd2,
        SLOT_RSV = 2'd3
    } slot_e;
endpackage

// File: rtl/pio_regfile.sv
// pio_regfile: set/clear attribute registers, change flags and read mux.
// Assumes at most one access per cycle and N_PINS <= DATA_W.
module pio_regfile
    import pio_pkg::*;
#(
    parameter int N_PINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [N_PINS-1:0] lvl,
    input  logic [N_PINS-1:0] evt,
    output logic [N_PINS-1:0] own,
    output logic [N_PINS-1:0] oe,
    output logic [N_PINS-1:0] dat,
    output logic [N_PINS-1:0] flt,
    output logic [N_PINS-1:0] md,
    output logic [N_PINS-1:0] pu,
    output logic [N_PINS-1:0] sel,
    output logic              irq
);
    logic [3:0]        grp;
    slot_e             slot;
    logic [N_PINS-1:0] cfg [NUM_CFG];
    logic [N_PINS-1:0] chg;
    logic [N_PINS-1:0] mask_w;
    logic [DATA_W-1:0] rmux;
    logic              rd_chg;

    assign grp    = addr[7:4];
    assign slot   = slot_e'(addr[3:2]);
    assign mask_w = wdata[N_PINS-1:0];
    assign rd_chg = rd && grp == G_CHG && slot == SLOT_STS;

    // One set/clear register per attribute; select swaps its slots (A clears, B sets)
    for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
        localparam slot_e SET_S = (g == int'(G_SEL)) ? SLOT_CLR : SLOT_SET;
        localparam slot_e CLR_S = (g == int'(G_SEL)) ? SLOT_SET : SLOT_CLR;
        localparam logic [N_PINS-1:0] RST_V =
            (g == int'(G_OWN) || g == int'(G_PU)) ? '1 : '0;

        // Apply write-one set or clear to this attribute
        always_ff @(posedge clk) begin
            if (!rst_n)
                cfg[g] <= RST_V;
            else if (wr && grp == 4'(g) && slot == SET_S)
                cfg[g] <= cfg[g] | mask_w;
            else if (wr && grp == 4'(g) && slot == CLR_S)
                cfg[g] <= cfg[g] & ~mask_w;
        end
    end

    assign own = cfg[G_OWN[2:0]];
    assign oe  = cfg[G_OE[2:0]];
    assign dat = cfg[G_DAT[2:0]];
    assign flt = cfg[G_FLT[2:0]];
    assign md  = cfg[G_MD[2:0]];
    assign pu  = cfg[G_PU[2:0]];
    assign sel = cfg[G_SEL[2:0]];

    // Change flags: cleared by a status read, new transitions win over the clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            chg <= '0;
        else
            chg <= (rd_chg ? '0 : chg) | evt;
    end

    assign irq = |(chg & cfg[G_IM[2:0]]);

    // Select the status word for the addressed group
    always_comb begin
        rmux = '0;
        if (slot == SLOT_STS) begin
            if (grp == G_PU)
                rmux[N_PINS-1:0] = ~pu;
            else if (grp < 4'(NUM_CFG))
                rmux[N_PINS-1:0] = cfg[grp[2:0]];
            else if (grp == G_LVL)
                rmux[N_PINS-1:0] = lvl;
            else if (grp == G_CHG)
                rmux[N_PINS-1:0] = chg;
        end
    end

    // Register read data one cycle after the strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd)
            rdata <= rmux;
    end

    AST_OWN_SET_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && grp == G_OWN && slot == SLOT_SET) |=> own == ($past(own) | $past(mask_w))); // R2
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_chg |=> (chg & ~$past(evt)) == '0); // R8
    AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && grp == G_SEL) |=> $stable(sel)); // R3
endmodule

// File: rtl/pio_insync.sv
// pio_insync: per-pin two-flop synchroniser, optional two-sample filter,
// and transition detect. Assumes pin inputs are asynchronous to clk.
module pio_insync #(
    parameter int N_PINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_in,
    input  logic [N_PINS-1:0] flt,
    output logic [N_PINS-1:0] lvl,
    output logic [N_PINS-1:0] evt
);
    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        logic s0, s1, pv, lv, nx;

        assign nx = flt[i] ? ((s1 == pv) ? s1 : lv) : s1;

        // Synchronise, keep the prior sample, and update the accepted level
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s0 <= 1'b0;
                s1 <= 1'b0;
                pv <= 1'b0;
                lv <= 1'b0;
            end else begin
                s0 <= pin_in[i];
                s1 <= s0;
                pv <= s1;
                lv <= nx;
            end
        end

        assign lvl[i] = lv;
        assign evt[i] = nx ^ lv;

        AST_FILTER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (flt[i] && s1 != pv) |=> $stable(lv)); // R7
    end
endmodule

// File: rtl/pio_pinmux.sv
// pio_pinmux: chooses each pad's drive source (controller, peripheral A or B)
// and applies open-drain masking. Purely combinational apart from the check.
module pio_pinmux #(
    parameter int N_PINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] own,
    input  logic [N_PINS-1:0] sel,
    input  logic [N_PINS-1:0] oe,
    input  logic [N_PINS-1:0] dat,
    input  logic [N_PINS-1:0] md,
    input  logic [N_PINS-1:0] a_out,
    input  logic [N_PINS-1:0] a_oe,
    input  logic [N_PINS-1:0] b_out,
    input  logic [N_PINS-1:0] b_oe,
    output logic [N_PINS-1:0] pad_out,
    output logic [N_PINS-1:0] pad_oe
);
    for (genvar i = 0; i < N_PINS; i++) begin : g_mux
        logic src_out, src_oe;
        // Pick the drive source for this pin
        always_comb begin
            if (own[i]) begin
                src_out = dat[i];
                src_oe  = oe[i];
            end else if (sel[i]) begin
                src_out = b_out[i];
                src_oe  = b_oe[i];
            end else begin
                src_out = a_out[i];
                src_oe  = a_oe[i];
            end
        end
        assign pad_out[i] = src_out & ~md[i];
        assign pad_oe[i]  = src_oe & ~(md[i] & src_out);
    end

    AST_OPEN_DRAIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & pad_out & md) == '0); // R4
endmodule

// File: rtl/pio_port_ctrl.sv
// pio_port_ctrl: top of the IO port controller. Connects the register file,
// the input stage and the pad mux. Assumes one bus access per cycle.
module pio_port_ctrl
    import pio_pkg::*;
#(
    parameter int N_PINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_PINS-1:0] pin_in,
    input  logic [N_PINS-1:0] alt_a_out,
    input  logic [N_PINS-1:0] alt_a_oe,
    input  logic [N_PINS-1:0] alt_b_out,
    input  logic [N_PINS-1:0] alt_b_oe,
    output logic [N_PINS-1:0] pad_out,
    output logic [N_PINS-1:0] pad_oe,
    output logic [N_PINS-1:0] pad_pullup,
    output logic              irq
);
    logic [N_PINS-1:0] own, oe, dat, flt, md, pu, sel, lvl, evt;

    pio_regfile #(.N_PINS(N_PINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata), .lvl(lvl), .evt(evt),
        .own(own), .oe(oe), .dat(dat), .flt(flt), .md(md), .pu(pu),
        .sel(sel), .irq(irq)
    );

    pio_insync #(.N_PINS(N_PINS)) u_in (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .flt(flt),
        .lvl(lvl), .evt(evt)
    );

    pio_pinmux #(.N_PINS(N_PINS)) u_mux (
        .clk(clk), .rst_n(rst_n), .own(own), .sel(sel), .oe(oe), .dat(dat),
        .md(md), .a_out(alt_a_out), .a_oe(alt_a_oe), .b_out(alt_b_out),
        .b_oe(alt_b_oe), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    assign pad_pullup = pu;
endmodule

// File: tb/tb_pio_port_ctrl.sv
module tb_pio_port_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  alt_a_out = '0, alt_a_oe = '1, alt_b_out = '1, alt_b_oe = '1;
    logic [N-1:0]  pad_out, pad_oe, pad_pullup;
    logic          irq;
    int            n_checks = 0, n_errors = 0;
    logic [31:0]   rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    pio_port_ctrl #(.N_PINS(N)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .alt_a_out(alt_a_out), .alt_a_oe(alt_a_oe),
        .alt_b_out(alt_b_out), .alt_b_oe(alt_b_oe), .pad_out(pad_out),
        .pad_oe(pad_oe), .pad_pullup(pad_pullup), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // All bus tasks start and end just after a falling edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0; d = bus_rdata;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        rd(8'h08, rv); chk("R1 own", rv, 32'hFFFF_FFFF);
        rd(8'h18, rv); chk("R1 dir", rv, 32'h0);
        rd(8'h28, rv); chk("R1 data", rv, 32'h0);
        rd(8'h58, rv); chk("R1 pullup status", rv, 32'h0);
        rd(8'h68, rv); chk("R1 mask", rv, 32'h0);
        rd(8'h98, rv); chk("R1 flags", rv, 32'h0);
        chk("R1 pad_pullup", pad_pullup, 32'hFFFF_FFFF);
        chk("R1 pad_oe", pad_oe, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_pairs;
        wr(8'h20, 32'h0000_00F0);
        wr(8'h24, 32'h0000_0030);
        rd(8'h28, rv); chk("R2 set then clear", rv, 32'h0000_00C0);
        wr(8'h20, 32'h0);
        wr(8'h24, 32'h0);
        rd(8'h28, rv); chk("R2 zero bits no effect", rv, 32'h0000_00C0);
    endtask

    task automatic t_mux;
        wr(8'h10, 32'h0000_00FF);
        chk("R3 own out", {24'b0, pad_out[7:0]}, 32'hC0);
        chk("R3 own oe", {24'b0, pad_oe[7:0]}, 32'hFF);
        wr(8'h04, 32'h0000_0030);
        wr(8'h74, 32'h0000_0020);
        alt_a_out = '0; alt_b_out = '1;
        #1;
        chk("R3 periph A/B out", {24'b0, pad_out[7:0]}, 32'hE0);
        rd(8'h08, rv); chk("R3 own status", rv, 32'hFFFF_FFCF);
        rd(8'h78, rv); chk("R3 select B status", rv, 32'h20);
        wr(8'h70, 32'h0000_0020);
        chk("R3 back to A", {24'b0, pad_out[7:0]}, 32'hC0);
        rd(8'h78, rv); chk("R3 select A status", rv, 32'h0);
    endtask

    task automatic t_md;
        wr(8'h40, 32'h0000_0081);
        chk("R4 open-drain oe", {24'b0, pad_oe[7:0]}, 32'h7F);
        chk("R4 open-drain out", {24'b0, pad_out[7:0]}, 32'h40);
        rd(8'h48, rv); chk("R4 status", rv, 32'h81);
    endtask

    task automatic t_pullup;
        wr(8'h54, 32'h0000_0008);
        chk("R5 pad_pullup", pad_pullup, 32'hFFFF_FFF7);
        rd(8'h58, rv); chk("R5 inverted status", rv, 32'h8);
    endtask

    task automatic t_level;
        pin_in[2] = 1'b1; pin_in[4] = 1'b1;
        edges(2);
        rd(8'h88, rv); chk("R6 not yet after 2 edges", rv, 32'h0);
        rd(8'h88, rv); chk("R6 level any owner", rv, 32'h14);
        rd(8'h98, rv); chk("R8 rising flags", rv, 32'h14);
        rd(8'h98, rv); chk("R8 cleared by read", rv, 32'h0);
    endtask

    task automatic t_collide;
        pin_in[2] = 1'b0;
        edges(2);
        rd(8'h98, rv); chk("R8 read in event cycle", rv, 32'h0);
        rd(8'h98, rv); chk("R8 falling flag kept", rv, 32'h4);
        rd(8'h98, rv); chk("R8 cleared after", rv, 32'h0);
    endtask

    task automatic t_filter;
        wr(8'h30, 32'h0000_0002);
        pin_in[1] = 1'b1; edges(0); pin_in[1] = 1'b0;
        edges(6);
        rd(8'h88, rv); chk("R7 pulse ignored level", rv & 32'h2, 32'h0);
        rd(8'h98, rv); chk("R7 pulse no flag", rv, 32'h0);
        pin_in[1] = 1'b1;
        edges(3);
        rd(8'h88, rv); chk("R7 held 3 edges not yet", rv & 32'h2, 32'h0);
        rd(8'h88, rv); chk("R7 accepted", rv & 32'h2, 32'h2);
        rd(8'h98, rv); chk("R7 accepted flag", rv, 32'h2);
        pin_in[3] = 1'b1; edges(0); pin_in[3] = 1'b0;
        edges(6);
        rd(8'h98, rv); chk("R7 unfiltered pulse flags", rv, 32'h8);
    endtask

    task automatic t_irq;
        wr(8'h60, 32'h0000_0001);
        pin_in[0] = 1'b1;
        edges(2);
        chk("R9 irq before accept", {31'b0, irq}, 32'h0);
        edges(1);
        chk("R9 irq raised", {31'b0, irq}, 32'h1);
        rd(8'h98, rv); chk("R9 flag", rv, 32'h1);
        chk("R9 irq dropped by read", {31'b0, irq}, 32'h0);
        pin_in[9] = 1'b1;
        edges(4);
        chk("R9 masked pin no irq", {31'b0, irq}, 32'h0);
        rd(8'h98, rv); chk("R9 masked flag present", rv, 32'h200);
    endtask

    task automatic t_map;
        rd(8'h00, rv); chk("R10 set slot reads 0", rv, 32'h0);
        rd(8'h24, rv); chk("R10 clear slot reads 0", rv, 32'h0);
        rd(8'hF8, rv); chk("R10 unused reads 0", rv, 32'h0);
        wr(8'h08, 32'h0);
        rd(8'h08, rv); chk("R10 status write ignored", rv, 32'hFFFF_FFCF);
        wr(8'h28, 32'hFFFF_FFFF);
        rd(8'h28, rv); chk("R10 data status write ignored", rv, 32'hC0);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin : main
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        edges(1);
        t_reset();
        t_pairs();
        t_mux();
        t_md();
        t_pullup();
        t_level();
        t_collide();
        t_filter();
        t_irq();
        t_map();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule